// File: doc/BRIEF.md
# Supply Reset Pulse Generator

This block creates the processor reset for a chip. It has two inputs that can cause a reset. The first is a supply-low flag, which an analog comparator has already turned into a clean synchronous bit. The second is an active-low manual-reset line. The block holds reset asserted while either cause is present. When both causes have cleared, it keeps reset asserted for one fixed stretch period and then releases it.

The stretch period is counted in clock cycles. A prescaler divides the system clock by `PRESCALE_DIV`. A tick counter then counts `TIMEOUT_TICKS` prescaler periods. A total of 200 ms is reached by choosing the two parameters to suit the clock frequency. Simulation uses small values. A new cause that appears during the stretch returns both counters to zero, so the full stretch runs again. This applies to a supply dip and to a manual press.

The manual-reset line passes through two synchronizing flops before it is used. The board is expected to pull this line high when nothing drives it, so that an undriven line reads as released. The block drives three outputs: an active-low reset, its active-high complement, and a reset-active status bit for neighbouring logic.

Top module: `supply_reset_gen`

## Requirements
- R1: While `supply_low` is 1, `reset_o` is 1 from the first clock edge that samples it.
- R2: Let N = `PRESCALE_DIV` * `TIMEOUT_TICKS`. When both causes have cleared, `reset_o` stays 1 through the first N edges that see no cause. It goes to 0 on edge N.
- R3: If `supply_low` returns to 1 before the stretch has finished, the stretch starts again from zero. After the cause clears again, a full N edges are counted.
- R4: While `man_rst_n` is held low, `reset_o` stays 1. The stretch of N edges counts from the synchronized release of `man_rst_n`.
- R5: `reset_n_o` is always the exact complement of `reset_o`, and `rst_active_o` is always equal to `reset_o`.
- R6: During synchronous `rst`, `reset_o` is 1. After `rst` is released, a full stretch of N edges runs before `reset_o` goes to 0.
- R7: `man_rst_n` passes through a two-flop synchronizer. A low level applied just after an edge has no effect on the outputs after two edges. It sets `reset_o` on the third edge. After a release, the first counted edge is the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| supply_low | input | 1 | Synchronous supply-low flag from the comparator |
| man_rst_n | input | 1 | Manual reset request, active low, asynchronous |
| reset_n_o | output | 1 | Processor reset, active low |
| reset_o | output | 1 | Processor reset, active high |
| rst_active_o | output | 1 | Reset-active status for other blocks |

## Verification
The bench samples the output on the exact edges before and after the release of reset, so the count of N edges is checked precisely. A counter that is off by one in the prescaler or in the tick counter fails one of those two checks. A supply dip is placed in the middle of a stretch. A design that only pauses the counters, or ignores the dip, then releases reset about ten cycles too early. Manual reset is checked on three points: the latency through the synchronizer, a long hold, and an overlap with a supply dip. A design that times its stretch from the wrong cause, or that skips the synchronizer, shows a release or an assertion edge that falls on the wrong cycle.

// File: rtl/supply_reset_gen.sv
module supply_reset_gen #(
  parameter int PRESCALE_DIV  = 1000,
  parameter int TIMEOUT_TICKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low,
  input  logic man_rst_n,
  output logic reset_n_o,
  output logic reset_o,
  output logic rst_active_o
);

  localparam int PW = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
  localparam int TW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(PRESCALE_DIV - 1);
  localparam logic [TW-1:0] TICK_LAST  = TW'(TIMEOUT_TICKS - 1);

  logic          mr_meta, mr_sync;
  logic [PW-1:0] presc;
  logic [TW-1:0] ticks;
  logic          rst_q;
  logic          hold, presc_wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      mr_meta <= 1'b1;
      mr_sync <= 1'b1;
    end else begin
      mr_meta <= man_rst_n;
      mr_sync <= mr_meta;
    end
  end

  assign hold       = supply_low | ~mr_sync;
  assign presc_wrap = (presc == PRESC_LAST);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      rst_q <= 1'b1;
      presc <= '0;
      ticks <= '0;
    end else if (rst_q) begin
      presc <= presc_wrap ? '0 : presc + 1'b1;
      if (presc_wrap) begin
        if (ticks == TICK_LAST) begin
          rst_q <= 1'b0;
          ticks <= '0;
        end else begin
          ticks <= ticks + 1'b1;
        end
      end
    end
  end

  assign reset_o      = rst_q;
  assign reset_n_o    = ~rst_q;
  assign rst_active_o = rst_q;

  AST_SUPPLY_HOLD: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> reset_o) else $error("supply hold");  // R1
  AST_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $fell(reset_o) |-> !$past(supply_low)) else $error("early release");  // R2
  AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (rst)
    presc <= PRESC_LAST && ticks <= TICK_LAST) else $error("counter range");  // R2
  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> (presc == '0 && ticks == '0)) else $error("no restart");  // R3
  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !mr_sync |=> reset_o) else $error("manual hold");  // R4
  AST_POWER_ON: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> reset_o) else $error("power-on");  // R6

endmodule

// File: tb/tb_supply_reset_gen.sv
module tb_supply_reset_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int TCK = 5;
  localparam int N = DIV * TCK;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_low = 1'b0;
  logic man_rst_n = 1'b1;
  logic reset_n_o, reset_o, rst_active_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_reset_gen #(.PRESCALE_DIV(DIV), .TIMEOUT_TICKS(TCK)) dut (
    .clk(clk), .rst(rst), .supply_low(supply_low), .man_rst_n(man_rst_n),
    .reset_n_o(reset_n_o), .reset_o(reset_o), .rst_active_o(rst_active_o)
  );

  // {supply_low, man_rst_n, edges, expected reset_o, requirement}
  typedef struct packed {
    logic       sl;
    logic       mrn;
    logic [7:0] edges;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 8'd1,      1'b1, 4'd1},
    '{1'b1, 1'b1, 8'd30,     1'b1, 4'd1},
    '{1'b0, 1'b1, 8'(N-1),   1'b1, 4'd2},
    '{1'b0, 1'b1, 8'd1,      1'b0, 4'd2},
    '{1'b1, 1'b1, 8'd1,      1'b1, 4'd1},
    '{1'b0, 1'b1, 8'd10,     1'b1, 4'd3},
    '{1'b1, 1'b1, 8'd1,      1'b1, 4'd3},
    '{1'b0, 1'b1, 8'(N-1),   1'b1, 4'd3},
    '{1'b0, 1'b1, 8'd1,      1'b0, 4'd3},
    '{1'b0, 1'b0, 8'd2,      1'b0, 4'd7},
    '{1'b0, 1'b0, 8'd1,      1'b1, 4'd7},
    '{1'b0, 1'b0, 8'd40,     1'b1, 4'd4},
    '{1'b0, 1'b1, 8'(N+1),   1'b1, 4'd4},
    '{1'b0, 1'b1, 8'd1,      1'b0, 4'd4},
    '{1'b1, 1'b0, 8'd5,      1'b1, 4'd1},
    '{1'b0, 1'b0, 8'd30,     1'b1, 4'd4},
    '{1'b0, 1'b1, 8'(N+1),   1'b1, 4'd7},
    '{1'b0, 1'b1, 8'd1,      1'b0, 4'd7}
  };

  task automatic check(input logic exp, input int req, input string what);
    checks++;
    if (reset_o !== exp) begin
      fails++;
      $display("FAIL R%0d %s: reset_o=%b expected %b", req, what, reset_o, exp);
    end
    checks++;
    if (reset_n_o !== ~exp || rst_active_o !== exp) begin  // R5
      fails++;
      $display("FAIL R5 %s: reset_n_o=%b rst_active_o=%b expected %b/%b",
               what, reset_n_o, rst_active_o, ~exp, exp);
    end
  endtask

  task automatic step(input logic sl, input logic mrn, input int n);
    supply_low = sl;
    man_rst_n  = mrn;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1'b1, 6, "during reset");                 // R6
    rst = 1'b0;
    step(1'b0, 1'b1, N-1);
    check(1'b1, 6, "power-on stretch edge N-1");    // R6
    step(1'b0, 1'b1, 1);
    check(1'b0, 6, "power-on release edge N");      // R6

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].sl, VECS[i].mrn, int'(VECS[i].edges));
      check(VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
    end

    // R6: synchronous reset in the middle of normal operation
    rst = 1'b1;
    step(1'b0, 1'b1, 1);
    check(1'b1, 6, "reset reapplied");
    rst = 1'b0;
    step(1'b0, 1'b1, N-1);
    check(1'b1, 6, "second power-on edge N-1");
    step(1'b0, 1'b1, 1);
    check(1'b0, 6, "second power-on edge N");

    // R7: a low manual level held for two edges only reaches the first flop stage and the second; released before the third it still gives a reset
    step(1'b0, 1'b0, 2);
    check(1'b0, 7, "short manual pulse latency");
    step(1'b0, 1'b1, 1);
    check(1'b1, 7, "short manual pulse takes effect");
    step(1'b0, 1'b1, N);
    check(1'b1, 4, "stretch after short press");
    step(1'b0, 1'b1, 1);
    check(1'b0, 4, "release after short press");

    // R3: supply dip on the last counting edge restarts the stretch
    step(1'b1, 1'b1, 1);
    step(1'b0, 1'b1, N-1);
    step(1'b1, 1'b1, 1);
    check(1'b1, 3, "dip at last edge");
    step(1'b0, 1'b1, N-1);
    check(1'b1, 3, "restart full length");
    step(1'b0, 1'b1, 1);
    check(1'b0, 3, "release after late dip");

    finish_run();
  end
endmodule